// File: doc/BRIEF.md
# Multiprocessor Boot Processor Election

This block decides which of a small group of processor agents becomes the bootstrap processor (BSP) after reset. The agents share one serialized broadcast channel. Each agent posts at most one boot request carrying its own ID. The channel delivers one message per cycle. Whichever request reaches the channel first decides the election. Its sender becomes the BSP, and every other agent becomes an application processor (AP) that waits for a startup message.

After the election, the channel itself queues a final message on behalf of the BSP. That message goes out only when every queued request has drained. When it arrives, the BSP begins fetching at the top-of-memory reset address. When the BSP signals the end of its boot code, a startup message carrying an 8-bit vector is broadcast, and each AP begins fetching at the page that the vector selects. The APs then take turns holding a single init-code semaphore, lowest ID first. A done flag rises when every AP has held the semaphore once.

Top module: `mp_boot_elect`

## Requirements
- R1: While `rst_n` is low at a clock edge, every agent returns to the unelected state. After that edge, `role_bsp`, `role_ap`, `fetch_valid`, `init_grant`, `bus_valid` and `done` are all zero, and `bus_kind` is 0.
- R2: The first boot request on the bus (`bus_kind` = 1) elects the agent whose ID equals `bus_src`. One cycle later that agent shows `role_bsp` and every other agent shows `role_ap`. Exactly one agent is ever the BSP.
- R3: After the election, a final message (`bus_kind` = 2, `bus_src` = BSP ID) is delivered exactly once, and only in a cycle after every pending boot request has been delivered.
- R4: A boot request delivered after the election changes no role. A second `req_post` from an agent that already posted since reset is dropped and produces no bus message.
- R5: One cycle after the final message, only the BSP raises `fetch_valid`, with `fetch_addr` = 0xFFFF_FFF0. APs do not react to the final message.
- R6: A `boot_done` pulse is accepted only once the final message has been delivered, and only the first accepted pulse counts. It latches `startup_vec` and queues a startup message (`bus_kind` = 3, `bus_data` = vector). One cycle after that message, each AP raises `fetch_valid` with `fetch_addr` = vector << 12. The BSP ignores it.
- R7: `init_grant` is one-hot or zero, and only ever goes to an AP that has received the startup message. When the semaphore is free, the lowest-ID AP still waiting gets it in the next cycle. A `sem_release` pulse frees the semaphore, and the holder counts as served. A pulse while the semaphore is free has no effect.
- R8: A request posted in cycle k is pending after edge k and is visible on the bus for exactly the one cycle after edge k+1, unless it is delayed behind other pending requests. The bus carries one message per cycle, with requests ahead of final and final ahead of startup. Pending requests go out starting from a rotating pointer, which is 0 after reset and moves to one past each delivered request's ID. Kind encoding: 0 idle, 1 boot request, 2 final, 3 startup.
- R9: `done` is high exactly when the election is settled, the final message has been delivered, and every AP has been served by the semaphore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_post | input | N_AGENTS | Per-agent boot request post pulse |
| boot_done | input | 1 | Pulse from the BSP at the end of its boot code |
| startup_vec | input | VEC_W | Vector carried by the startup message |
| sem_release | input | 1 | Release pulse from the current semaphore holder |
| role_bsp | output | N_AGENTS | Agent is the bootstrap processor |
| role_ap | output | N_AGENTS | Agent is an application processor |
| fetch_valid | output | N_AGENTS | Agent has started fetching |
| fetch_addr | output | N_AGENTS*ADDR_W | Per-agent fetch start address, agent i in bits [i*ADDR_W +: ADDR_W] |
| init_grant | output | N_AGENTS | Init-code semaphore grant |
| bus_valid | output | 1 | A message is on the shared bus this cycle |
| bus_kind | output | 2 | Message kind (0 idle, 1 request, 2 final, 3 startup) |
| bus_src | output | ID_W | Sender ID of the message |
| bus_data | output | VEC_W | Startup vector (0 for other kinds) |
| done | output | 1 | Election, final delivery and all semaphore grants complete |

## Verification
The bench builds the block with its defaults: four agents, an 8-bit vector and 32-bit addresses. Four agents are enough to exercise the rotating pointer wrapping past the highest ID. They also leave room for several requests to stay queued behind the winner, which holds the final message back, and for three APs to take the semaphore in turn. The scenarios include a simultaneous post by all agents, a lone early winner followed by a burst, a late request that slips in before the final message, and one that arrives after it. Early `boot_done` pulses and releases while the semaphore is free are also driven.

// File: rtl/mp_boot_pkg.sv
// Shared types for the boot processor election block.
// Assumes the bus message kind always fits in two bits.
package mp_boot_pkg;

    typedef enum logic [1:0] {
        MSG_IDLE     = 2'd0,
        MSG_BOOT_REQ = 2'd1,
        MSG_FINAL    = 2'd2,
        MSG_STARTUP  = 2'd3
    } msg_kind_t;

    typedef enum logic [2:0] {
        AG_UNELECTED = 3'd0,
        AG_BSP_WAIT  = 3'd1,
        AG_BSP_RUN   = 3'd2,
        AG_AP_WAIT   = 3'd3,
        AG_AP_RUN    = 3'd4
    } agent_state_t;

    localparam int unsigned AP_PAGE_SHIFT = 12;

endpackage

// File: rtl/mpb_msg_bus.sv
// Serialized broadcast channel. Holds one pending boot request per agent,
// plus a final message and a startup message that the channel posts for the BSP.
// Delivers one message per cycle in priority order: requests first (rotating
// pointer), then final, then startup.
// Assumes: req_post and boot_done are single-cycle pulses from the clk domain.
module mpb_msg_bus
    import mp_boot_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int ID_W     = 2,
    parameter int VEC_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_AGENTS-1:0] req_post,
    input  logic                boot_done,
    input  logic [VEC_W-1:0]    startup_vec,
    output logic                bus_valid,
    output msg_kind_t           bus_kind,
    output logic [ID_W-1:0]     bus_src,
    output logic [VEC_W-1:0]    bus_data,
    output logic                final_sent,
    output logic                settled
);

    logic [N_AGENTS-1:0] posted_q, pend_q, pick_mask;
    logic [ID_W-1:0]     ptr_q, bsp_q, pick_id;
    logic                pick_found;
    logic                final_pend_q, final_sent_q, settled_q;
    logic                start_posted_q, start_pend_q;
    logic [VEC_W-1:0]    vec_q;
    logic                settle_now, start_accept, take_final, take_start;

    // Rotating search for the first pending request at or after the pointer.
    always_comb begin
        pick_found = 1'b0;
        pick_id    = '0;
        pick_mask  = '0;
        for (int j = 0; j < N_AGENTS; j++) begin
            int idx;
            idx = int'(ptr_q) + j;
            if (idx >= N_AGENTS) idx = idx - N_AGENTS;
            if (!pick_found && pend_q[idx]) begin
                pick_found = 1'b1;
                pick_id    = ID_W'(idx);
            end
        end
        if (pick_found) pick_mask[pick_id] = 1'b1;
    end

    // Decode the channel's own events for this cycle.
    assign settle_now   = bus_valid && (bus_kind == MSG_BOOT_REQ) && !settled_q;
    assign start_accept = boot_done && final_sent_q && !start_posted_q;
    assign take_final   = !pick_found && final_pend_q;
    assign take_start   = !pick_found && !final_pend_q && start_pend_q;

    // Track which agents have posted and which requests are still queued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            posted_q <= '0;
            pend_q   <= '0;
        end else begin
            posted_q <= posted_q | req_post;
            pend_q   <= (pend_q & ~pick_mask) | (req_post & ~posted_q);
        end
    end

    // Advance the rotating pointer past each delivered request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (pick_found) begin
            ptr_q <= (int'(pick_id) == N_AGENTS - 1) ? '0 : pick_id + 1'b1;
        end
    end

    // Settle the election and queue the final message on the first request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settled_q    <= 1'b0;
            bsp_q        <= '0;
            final_pend_q <= 1'b0;
            final_sent_q <= 1'b0;
        end else begin
            if (settle_now) begin
                settled_q    <= 1'b1;
                bsp_q        <= bus_src;
                final_pend_q <= 1'b1;
            end else if (take_final) begin
                final_pend_q <= 1'b0;
            end
            if (bus_valid && bus_kind == MSG_FINAL) final_sent_q <= 1'b1;
        end
    end

    // Accept the end-of-boot pulse once and queue the startup message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_posted_q <= 1'b0;
            start_pend_q   <= 1'b0;
            vec_q          <= '0;
        end else begin
            if (start_accept) begin
                start_posted_q <= 1'b1;
                start_pend_q   <= 1'b1;
                vec_q          <= startup_vec;
            end else if (take_start) begin
                start_pend_q <= 1'b0;
            end
        end
    end

    // Load the single bus slot with the chosen message for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_valid <= 1'b0;
            bus_kind  <= MSG_IDLE;
            bus_src   <= '0;
            bus_data  <= '0;
        end else if (pick_found) begin
            bus_valid <= 1'b1;
            bus_kind  <= MSG_BOOT_REQ;
            bus_src   <= pick_id;
            bus_data  <= '0;
        end else if (take_final) begin
            bus_valid <= 1'b1;
            bus_kind  <= MSG_FINAL;
            bus_src   <= bsp_q;
            bus_data  <= '0;
        end else if (take_start) begin
            bus_valid <= 1'b1;
            bus_kind  <= MSG_STARTUP;
            bus_src   <= bsp_q;
            bus_data  <= vec_q;
        end else begin
            bus_valid <= 1'b0;
            bus_kind  <= MSG_IDLE;
            bus_src   <= '0;
            bus_data  <= '0;
        end
    end

    assign final_sent = final_sent_q;
    assign settled    = settled_q;

    // R3: the final message appears on the bus only once per reset.
    p_final_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind == MSG_FINAL) |-> !final_sent_q);

    // R8: a startup message never precedes delivery of the final message.
    p_startup_after_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind == MSG_STARTUP) |-> final_sent_q);

endmodule

// File: rtl/mpb_agent.sv
// One processor agent. Watches the shared bus, takes its role from the first
// boot request, starts fetching on final (BSP) or startup (AP).
// Assumes: bus fields are registered and valid for one cycle per message.
module mpb_agent
    import mp_boot_pkg::*;
#(
    parameter int AGENT_ID = 0,
    parameter int ID_W     = 2,
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  msg_kind_t         bus_kind,
    input  logic [ID_W-1:0]   bus_src,
    input  logic [VEC_W-1:0]  bus_data,
    output logic              is_bsp,
    output logic              is_ap,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              sipi_seen
);

    localparam logic [ADDR_W-1:0] BSP_VECTOR = {{(ADDR_W-4){1'b1}}, 4'h0};
    localparam logic [ID_W-1:0]   MY_ID      = ID_W'(AGENT_ID);

    agent_state_t state_q;

    // Role and boot progress state machine driven by bus messages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= AG_UNELECTED;
            fetch_addr <= '0;
        end else if (bus_valid) begin
            unique case (state_q)
                AG_UNELECTED: if (bus_kind == MSG_BOOT_REQ)
                    state_q <= (bus_src == MY_ID) ? AG_BSP_WAIT : AG_AP_WAIT;
                AG_BSP_WAIT: if (bus_kind == MSG_FINAL) begin
                    state_q    <= AG_BSP_RUN;
                    fetch_addr <= BSP_VECTOR;
                end
                AG_AP_WAIT: if (bus_kind == MSG_STARTUP) begin
                    state_q    <= AG_AP_RUN;
                    fetch_addr <= ADDR_W'({bus_data, {AP_PAGE_SHIFT{1'b0}}});
                end
                default: ;
            endcase
        end
    end

    // Decode role outputs from the current state.
    assign is_bsp      = (state_q == AG_BSP_WAIT) || (state_q == AG_BSP_RUN);
    assign is_ap       = (state_q == AG_AP_WAIT)  || (state_q == AG_AP_RUN);
    assign fetch_valid = (state_q == AG_BSP_RUN)  || (state_q == AG_AP_RUN);
    assign sipi_seen   = (state_q == AG_AP_RUN);

    // R4: once a role is taken it is never dropped before reset.
    p_role_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bsp || is_ap) |=> (is_bsp || is_ap) && $stable(is_bsp));

    // R5: the fetch start, once issued, holds its address.
    p_fetch_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> fetch_valid && $stable(fetch_addr));

endmodule

// File: rtl/mpb_init_sem.sv
// Init-code semaphore shared by the application processors. Grants the
// lowest-ID waiting AP, holds until a release pulse, marks the holder served.
// Assumes: sipi_seen bits are sticky until reset.
module mpb_init_sem #(
    parameter int N_AGENTS = 4,
    parameter int ID_W     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_AGENTS-1:0] sipi_seen,
    input  logic                release_i,
    output logic [N_AGENTS-1:0] grant,
    output logic [N_AGENTS-1:0] served
);

    logic                holder_v;
    logic [ID_W-1:0]     holder_id, next_id;
    logic                next_found;
    logic [N_AGENTS-1:0] waiting;

    assign waiting = sipi_seen & ~served;

    // Find the lowest-ID waiting agent.
    always_comb begin
        next_found = 1'b0;
        next_id    = '0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (waiting[i]) begin
                next_found = 1'b1;
                next_id    = ID_W'(i);
            end
        end
    end

    // Hand out, hold and release the semaphore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holder_v  <= 1'b0;
            holder_id <= '0;
            served    <= '0;
        end else if (holder_v) begin
            if (release_i) begin
                holder_v          <= 1'b0;
                served[holder_id] <= 1'b1;
            end
        end else if (next_found) begin
            holder_v  <= 1'b1;
            holder_id <= next_id;
        end
    end

    // Drive the one grant line of the current holder.
    always_comb begin
        grant = '0;
        if (holder_v) grant[holder_id] = 1'b1;
    end

    // R7: at most one grant at a time.
    p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: a held grant stays with its holder until released.
    p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (holder_v && !release_i) |=> holder_v && $stable(holder_id));

    // R7: a release always frees the semaphore for a cycle.
    p_release_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (holder_v && release_i) |=> !holder_v);

endmodule

// File: rtl/mp_boot_elect.sv
// Top level of the boot processor election. Connects the broadcast channel,
// one agent per processor and the init semaphore, and forms the done flag.
// Assumes: ADDR_W >= VEC_W + 12 and N_AGENTS >= 1.
module mp_boot_elect
    import mp_boot_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 32,
    localparam int ID_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_AGENTS-1:0]        req_post,
    input  logic                       boot_done,
    input  logic [VEC_W-1:0]           startup_vec,
    input  logic                       sem_release,
    output logic [N_AGENTS-1:0]        role_bsp,
    output logic [N_AGENTS-1:0]        role_ap,
    output logic [N_AGENTS-1:0]        fetch_valid,
    output logic [N_AGENTS*ADDR_W-1:0] fetch_addr,
    output logic [N_AGENTS-1:0]        init_grant,
    output logic                       bus_valid,
    output logic [1:0]                 bus_kind,
    output logic [ID_W-1:0]            bus_src,
    output logic [VEC_W-1:0]           bus_data,
    output logic                       done
);

    msg_kind_t           kind_w;
    logic                final_sent, settled;
    logic [N_AGENTS-1:0] sipi_seen, served;

    mpb_msg_bus #(.N_AGENTS(N_AGENTS), .ID_W(ID_W), .VEC_W(VEC_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_post   (req_post),
        .boot_done  (boot_done),
        .startup_vec(startup_vec),
        .bus_valid  (bus_valid),
        .bus_kind   (kind_w),
        .bus_src    (bus_src),
        .bus_data   (bus_data),
        .final_sent (final_sent),
        .settled    (settled)
    );

    assign bus_kind = kind_w;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        mpb_agent #(.AGENT_ID(g), .ID_W(ID_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_agent (
            .clk        (clk),
            .rst_n      (rst_n),
            .bus_valid  (bus_valid),
            .bus_kind   (kind_w),
            .bus_src    (bus_src),
            .bus_data   (bus_data),
            .is_bsp     (role_bsp[g]),
            .is_ap      (role_ap[g]),
            .fetch_valid(fetch_valid[g]),
            .fetch_addr (fetch_addr[g*ADDR_W +: ADDR_W]),
            .sipi_seen  (sipi_seen[g])
        );
    end

    mpb_init_sem #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_sem (
        .clk      (clk),
        .rst_n    (rst_n),
        .sipi_seen(sipi_seen),
        .release_i(sem_release),
        .grant    (init_grant),
        .served   (served)
    );

    // Completion: election settled, final delivered, every AP served once.
    assign done = settled && final_sent && ((role_ap & ~served) == '0);

    // R2: never more than one BSP.
    p_single_bsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(role_bsp));

    // R2: an agent is never both BSP and AP.
    p_roles_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (role_bsp & role_ap) == '0);

    // R3: a final message is only sent once a BSP exists.
    p_final_has_bsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && kind_w == MSG_FINAL) |-> (role_bsp != '0));

    // R7: the semaphore is only ever granted to an AP.
    p_grant_ap_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (init_grant & ~role_ap) == '0);

    // R9: done implies the BSP has started fetching.
    p_done_after_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((role_bsp & fetch_valid) != '0));

endmodule

// File: tb/mp_boot_elect_test.sv
// Bench for mp_boot_elect: behavioural reference model stepped once per clock
// and compared against every output after each edge.
module mp_boot_elect_test;

    localparam int N  = 4;
    localparam int VW = 8;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req_post = '0;
    logic          boot_done = 1'b0;
    logic [VW-1:0] startup_vec = '0;
    logic          sem_release = 1'b0;
    logic [N-1:0]  role_bsp, role_ap, fetch_valid, init_grant;
    logic [N*AW-1:0] fetch_addr;
    logic          bus_valid, done;
    logic [1:0]    bus_kind;
    logic [1:0]    bus_src;
    logic [VW-1:0] bus_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    mp_boot_elect #(.N_AGENTS(N), .VEC_W(VW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_post(req_post), .boot_done(boot_done),
        .startup_vec(startup_vec), .sem_release(sem_release),
        .role_bsp(role_bsp), .role_ap(role_ap), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .init_grant(init_grant), .bus_valid(bus_valid),
        .bus_kind(bus_kind), .bus_src(bus_src), .bus_data(bus_data), .done(done)
    );

    always #4 clk = ~clk;

    // Reference model state (role: 0 none, 1 BSP, 2 AP).
    int m_posted[N], m_pend[N], m_role[N], m_fv[N], m_start[N], m_served[N];
    longint m_fa[N];
    int m_ptr, m_bv, m_bk, m_bs, m_bd, m_settled, m_fpend, m_fsent;
    int m_sposted, m_spend, m_vec, m_bsp, m_hv, m_hid;

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_posted[i] = 0; m_pend[i] = 0; m_role[i] = 0; m_fv[i] = 0;
            m_start[i] = 0; m_served[i] = 0; m_fa[i] = 0;
        end
        m_ptr = 0; m_bv = 0; m_bk = 0; m_bs = 0; m_bd = 0; m_settled = 0;
        m_fpend = 0; m_fsent = 0; m_sposted = 0; m_spend = 0; m_vec = 0;
        m_bsp = 0; m_hv = 0; m_hid = 0;
    endtask

    task automatic model_step(input logic [N-1:0] post, input logic bend,
                              input int vec, input logic rel);
        int o_pend[N], o_posted[N], o_start[N], o_served[N];
        int o_bv, o_bk, o_bs, o_bd, o_settled, o_fpend, o_fsent, o_spend, o_vec, o_bsp, o_ptr;
        int found, pick;
        for (int i = 0; i < N; i++) begin
            o_pend[i] = m_pend[i]; o_posted[i] = m_posted[i];
            o_start[i] = m_start[i]; o_served[i] = m_served[i];
        end
        o_bv = m_bv; o_bk = m_bk; o_bs = m_bs; o_bd = m_bd; o_settled = m_settled;
        o_fpend = m_fpend; o_fsent = m_fsent; o_spend = m_spend; o_vec = m_vec;
        o_bsp = m_bsp; o_ptr = m_ptr;
        // agents react to the message currently on the bus
        for (int i = 0; i < N; i++) begin
            if (o_bv != 0) begin
                if (m_role[i] == 0 && o_bk == 1) m_role[i] = (o_bs == i) ? 1 : 2;
                else if (m_role[i] == 1 && o_bk == 2 && m_fv[i] == 0) begin
                    m_fv[i] = 1; m_fa[i] = 64'hFFFF_FFF0;
                end else if (m_role[i] == 2 && o_bk == 3 && o_start[i] == 0) begin
                    m_start[i] = 1; m_fv[i] = 1; m_fa[i] = longint'(o_bd) * 4096;
                end
            end
        end
        if (o_bv != 0 && o_bk == 1 && o_settled == 0) begin
            m_settled = 1; m_fpend = 1; m_bsp = o_bs;
        end
        if (o_bv != 0 && o_bk == 2) m_fsent = 1;
        if (bend && o_fsent != 0 && m_sposted == 0) begin
            m_sposted = 1; m_spend = 1; m_vec = vec;
        end
        // bus slot
        found = 0; pick = 0;
        for (int j = 0; j < N; j++) begin
            int idx;
            idx = (o_ptr + j) % N;
            if (found == 0 && o_pend[idx] != 0) begin found = 1; pick = idx; end
        end
        if (found != 0) begin
            m_bv = 1; m_bk = 1; m_bs = pick; m_bd = 0;
            m_pend[pick] = 0; m_ptr = (pick + 1) % N;
        end else if (o_fpend != 0) begin
            m_bv = 1; m_bk = 2; m_bs = o_bsp; m_bd = 0; m_fpend = 0;
        end else if (o_spend != 0) begin
            m_bv = 1; m_bk = 3; m_bs = o_bsp; m_bd = o_vec; m_spend = 0;
        end else begin
            m_bv = 0; m_bk = 0; m_bs = 0; m_bd = 0;
        end
        for (int i = 0; i < N; i++) begin
            if (post[i] && o_posted[i] == 0) m_pend[i] = 1;
            if (post[i]) m_posted[i] = 1;
        end
        // semaphore
        if (m_hv != 0) begin
            if (rel) begin m_hv = 0; m_served[m_hid] = 1; end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (o_start[i] != 0 && o_served[i] == 0) begin m_hv = 1; m_hid = i; end
            end
        end
    endtask

    function automatic int model_done();
        int d;
        d = (m_settled != 0 && m_fsent != 0) ? 1 : 0;
        for (int i = 0; i < N; i++) if (m_role[i] == 2 && m_served[i] == 0) d = 0;
        return d;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < N; i++) begin
            chk("R2 role_bsp", longint'(role_bsp[i]), (m_role[i] == 1) ? 1 : 0);
            chk("R2 role_ap", longint'(role_ap[i]), (m_role[i] == 2) ? 1 : 0);
            if (m_role[i] == 1) begin
                chk("R5 bsp fetch_valid", longint'(fetch_valid[i]), m_fv[i]);
                if (m_fv[i] != 0) chk("R5 bsp fetch_addr", longint'(fetch_addr[i*AW +: AW]), m_fa[i]);
            end else begin
                chk("R6 ap fetch_valid", longint'(fetch_valid[i]), m_fv[i]);
                if (m_fv[i] != 0) chk("R6 ap fetch_addr", longint'(fetch_addr[i*AW +: AW]), m_fa[i]);
            end
            chk("R7 init_grant", longint'(init_grant[i]), (m_hv != 0 && m_hid == i) ? 1 : 0);
        end
        chk("R8 bus_valid", longint'(bus_valid), m_bv);
        chk((m_bk == 2) ? "R3 bus_kind" : "R8 bus_kind", longint'(bus_kind), m_bk);
        chk("R8 bus_src", longint'(bus_src), m_bs);
        chk("R6 bus_data", longint'(bus_data), m_bd);
        chk("R9 done", longint'(done), model_done());
    endtask

    // One clock: drive at negedge, step model, compare after the edge.
    task automatic cyc(input logic [N-1:0] post, input logic bend,
                       input logic [VW-1:0] vec, input logic rel);
        req_post = post; boot_done = bend; startup_vec = vec; sem_release = rel;
        if (rst_n) model_step(post, bend, int'(vec), rel);
        else model_reset();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc('0, 1'b0, '0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic serve_aps(input int n);
        for (int k = 0; k < n; k++) begin
            idle(2);
            cyc('0, 1'b0, '0, 1'b1);
        end
        idle(3);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cycles);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Scenario A: all agents post together; pointer 0 makes agent 0 BSP.
        do_reset();
        chk("R1 reset role_bsp", longint'(role_bsp), 0);
        chk("R1 reset fetch_valid", longint'(fetch_valid), 0);
        chk("R1 reset bus_valid", longint'(bus_valid), 0);
        chk("R1 reset done", longint'(done), 0);
        cyc(4'b1111, 1'b0, '0, 1'b0);
        idle(9);
        chk("R2 scenario A bsp", longint'(role_bsp), 4'b0001);
        cyc('0, 1'b1, 8'h9A, 1'b0);
        idle(4);
        serve_aps(3);
        chk("R9 scenario A done", longint'(done), 1);

        // Scenario B: agent 2 wins alone, burst behind it, repost, early boot_done.
        do_reset();
        cyc(4'b0100, 1'b0, '0, 1'b0);
        cyc(4'b1111, 1'b0, '0, 1'b0);     // R4: agent 2 repost dropped
        cyc('0, 1'b1, 8'h11, 1'b0);       // R6: boot_done before final ignored
        idle(2);
        cyc('0, 1'b0, '0, 1'b1);          // R7: release with no holder ignored
        idle(6);
        chk("R2 scenario B bsp", longint'(role_bsp), 4'b0100);
        cyc('0, 1'b1, 8'hFF, 1'b0);
        cyc('0, 1'b1, 8'h22, 1'b0);       // R6: second boot_done ignored
        idle(4);
        chk("R6 scenario B ap0 addr", longint'(fetch_addr[0 +: AW]), 32'h000F_F000);
        serve_aps(3);

        // Scenario C: late request before final, another after final.
        do_reset();
        cyc(4'b0010, 1'b0, '0, 1'b0);
        idle(1);
        cyc(4'b1000, 1'b0, '0, 1'b0);     // R4: delivered after election, ignored
        idle(6);
        cyc(4'b0001, 1'b0, '0, 1'b0);     // R4: delivered after final, ignored
        idle(3);
        chk("R4 scenario C roles", longint'(role_ap), 4'b1101);
        cyc('0, 1'b1, 8'h3C, 1'b0);
        idle(4);
        chk("R6 scenario C ap3 addr", longint'(fetch_addr[3*AW +: AW]), 32'h0003_C000);
        cyc('0, 1'b0, '0, 1'b1);
        cyc('0, 1'b0, '0, 1'b1);          // R7: back-to-back, second while free
        serve_aps(3);
        chk("R9 scenario C done", longint'(done), 1);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule